// File: doc/BRIEF.md
# Transparent FIFO Serial Transmitter

This block shifts raw bytes from a small transmit FIFO onto one serial data line. It adds no framing of any kind: no flag octets, no checksum and no zero-bit insertion. Each stored byte reaches the line exactly as written, least significant bit first. A host loads bytes and issues commands through a small register port with three addresses. Outside logic supplies a bit-clock enable, and the line advances one bit on each enable pulse.

There are two ways to send. A one-shot transmission drains the FIFO and raises an end-of-transmission status flag once the last bit has been on the line for its full bit time. A cyclic transmission keeps the stored bytes and replays them in a loop until the host writes the transmitter-reset command. After that command the line rests at logic one. During cyclic sending the FIFO is frozen, so data writes have no effect.

The register map is as follows. Address 0 is the FIFO data window (write only). Address 1 takes commands (write only). Address 2 is status (read only), with end-of-transmission in bit 6, mask 40h. The command bits are:

| Bit | Mask | Meaning |
|-----|------|---------|
| 0 | 01h | transmitter reset |
| 1 | 02h | message end |
| 3 | 08h | start |
| 5 | 20h | repeat |

Top module: `xparent_serial_tx`

## Requirements
- R1: After reset, `txd` is 1 and a status read (address 2) returns 00h. Whenever no transmission is active, `txd` is 1.
- R2: Command 08h (start, bit 3) with a non-empty FIFO sends the stored bytes in write order. Each byte goes out unchanged, least significant bit first. Each `bit_en` pulse puts the next bit on `txd` one clock later.
- R3: In a one-shot transmission, the next `bit_en` after the last bit of the last byte returns `txd` to 1 and sets status bit 6 (40h).
- R4: A status read returns the flag. The read then clears it, so the next read returns 00h unless a new end of transmission has occurred.
- R5: Command 2Ah (repeat bit 5, start bit 3 and message-end bit 1 together) with 1 to 32 stored bytes sends those bytes in a loop. The first byte follows the last one, and the stored data is kept.
- R6: Command 01h (transmitter reset, bit 0) stops any transmission, forces `txd` to 1 on the next clock and empties the FIFO. It does not set the status flag. Reset takes priority over start in the same command byte.
- R7: Writes to the data window during cyclic transmission are ignored. The looped byte sequence stays the same.
- R8: The FIFO holds 32 bytes. A data write to a full FIFO is ignored.
- R9: A start command has no effect while the FIFO is empty or while a transmission is in progress.
- R10: A start with the repeat bit but without message end (28h) behaves as a one-shot transmission and ends with the status flag.
- R11: `txd` changes only on a clock where `bit_en` was high or a transmitter-reset command was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable, one pulse per line bit |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (clears the status on address 2) |
| addr | input | 2 | Register address: 0 data, 1 command, 2 status |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| txd | output | 1 | Serial data line, idle high |

## Verification
A wrong read pointer or a wrong loop offset shows up as a wrong bit on `txd` within eight `bit_en` pulses of the bad fetch. The bench compares every line bit against a byte model, so such an error is caught in the same bit period. A wrong FIFO count appears as a transmission that ends early, late or not at all. The first missing or extra byte exposes it, and a stray or absent 40h flag confirms it at the next status read. A stuck cyclic flag appears as idle-high loss after the reset command, and it is caught on the next clock.

// File: rtl/xparent_serial_tx_pkg.sv
// Package: shared constants and types for the transparent serial transmitter.
// Assumes a byte-wide host port and a two-bit register address.
package xparent_serial_tx_pkg;
    localparam int unsigned BYTE_W = 8;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CMD  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int unsigned CMD_XRES  = 0;
    localparam int unsigned CMD_MEND  = 1;
    localparam int unsigned CMD_START = 3;
    localparam int unsigned CMD_REP   = 5;

    localparam int unsigned STAT_EOT  = 6;

    typedef enum logic {ST_IDLE = 1'b0, ST_SEND = 1'b1} tx_state_t;
endpackage

// File: rtl/xparent_fifo.sv
// Module: byte FIFO with two read modes.
// In consume mode a pop removes the head entry. In loop mode an offset walks
// over the stored entries and wraps without removing them. Assumes DEPTH is a
// power of two, so the pointers wrap naturally.
module xparent_fifo #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          adv,
    input  logic          clear,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] offset;
    logic          do_push;
    logic [AW-1:0] rd_idx;

    assign do_push = push && (count < CW'(DEPTH));
    assign rd_idx  = rd_ptr + offset;
    assign head    = mem[rd_idx];

    // Storage write: accept a byte only while there is room.
    always_ff @(posedge clk) begin
        if (do_push && !clear) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer, count and loop-offset bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            offset <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({do_push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (adv) begin
                offset <= ({1'b0, offset} == count - 1'b1) ? '0 : offset + 1'b1;
            end
        end
    end
endmodule

// File: rtl/xparent_regs.sv
// Module: host register decode and status flag.
// Turns host writes into a FIFO push and command pulses, and holds the
// end-of-transmission flag, which is cleared by a status read. Data writes are
// blocked while cyclic sending is active.
module xparent_regs
    import xparent_serial_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              cyc_active,
    input  logic              eot_set,
    output logic              push,
    output logic              cmd_start,
    output logic              cmd_rep,
    output logic              cmd_mend,
    output logic              cmd_xres,
    output logic              eot_flag,
    output logic [BYTE_W-1:0] rdata
);
    logic cmd_wr;

    assign cmd_wr    = wr_en && (addr == ADDR_CMD);
    assign push      = wr_en && (addr == ADDR_DATA) && !cyc_active;
    assign cmd_xres  = cmd_wr && wdata[CMD_XRES];
    assign cmd_start = cmd_wr && wdata[CMD_START];
    assign cmd_rep   = wdata[CMD_REP];
    assign cmd_mend  = wdata[CMD_MEND];

    // Status flag: a new end event wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eot_flag <= 1'b0;
        end else if (eot_set) begin
            eot_flag <= 1'b1;
        end else if (rd_en && (addr == ADDR_STAT)) begin
            eot_flag <= 1'b0;
        end
    end

    // Read mux: only the status address returns data.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_STAT) begin
            rdata[STAT_EOT] = eot_flag;
        end
    end
endmodule

// File: rtl/xparent_engine.sv
// Module: transmit sequencer and serializer.
// Fetches bytes from the FIFO and shifts them out LSB first, one bit per
// bit_en. In one-shot mode it consumes bytes and reports the end. In cyclic
// mode it advances the loop offset. Assumes the FIFO head is valid whenever
// the count is non-zero.
module xparent_engine
    import xparent_serial_tx_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              cmd_start,
    input  logic              cmd_rep,
    input  logic              cmd_mend,
    input  logic              cmd_xres,
    input  logic [CW-1:0]     fifo_count,
    input  logic [BYTE_W-1:0] fifo_head,
    output logic              pop,
    output logic              adv,
    output logic              eot_set,
    output logic              busy,
    output logic              cyc_active,
    output logic              txd
);
    localparam int unsigned BCW = $clog2(BYTE_W + 1);

    tx_state_t         state;
    logic [BYTE_W-2:0] shreg;
    logic [BCW-1:0]    bits_left;
    logic              need_byte;
    logic              have_byte;
    logic              accept;

    assign busy      = (state == ST_SEND);
    assign need_byte = busy && bit_en && (bits_left == '0);
    assign have_byte = cyc_active || (fifo_count != '0);
    assign pop       = need_byte && have_byte && !cyc_active && !cmd_xres;
    assign adv       = need_byte && cyc_active && !cmd_xres;
    assign eot_set   = need_byte && !have_byte && !cmd_xres;
    assign accept    = cmd_start && !busy && (fifo_count != '0) && !cmd_xres;

    // Sequencer and shifter: reset command first, then start, then bit timing.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_xres) begin
            state      <= ST_IDLE;
            cyc_active <= 1'b0;
            shreg      <= '0;
            bits_left  <= '0;
            txd        <= 1'b1;
        end else if (accept) begin
            state      <= ST_SEND;
            cyc_active <= cmd_rep && cmd_mend;
            bits_left  <= '0;
        end else if (busy && bit_en) begin
            if (bits_left != '0) begin
                txd       <= shreg[0];
                shreg     <= shreg >> 1;
                bits_left <= bits_left - 1'b1;
            end else if (have_byte) begin
                txd       <= fifo_head[0];
                shreg     <= fifo_head[BYTE_W-1:1];
                bits_left <= BCW'(BYTE_W - 1);
            end else begin
                txd   <= 1'b1;
                state <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/xparent_serial_tx.sv
// Module: top of the transparent FIFO serial transmitter.
// Connects the host register decode, the byte FIFO and the transmit engine.
// Assumes bit_en comes from an external bit-rate generator in the clk domain.
module xparent_serial_tx
    import xparent_serial_tx_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              txd
);
    localparam int unsigned CW = $clog2(DEPTH) + 1;

    logic              push;
    logic              cmd_start;
    logic              cmd_rep;
    logic              cmd_mend;
    logic              cmd_xres;
    logic              eot_flag;
    logic              eot_set;
    logic              busy;
    logic              cyc_active;
    logic              pop;
    logic              adv;
    logic [CW-1:0]     fifo_count;
    logic [BYTE_W-1:0] fifo_head;

    xparent_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .cyc_active (cyc_active),
        .eot_set    (eot_set),
        .push       (push),
        .cmd_start  (cmd_start),
        .cmd_rep    (cmd_rep),
        .cmd_mend   (cmd_mend),
        .cmd_xres   (cmd_xres),
        .eot_flag   (eot_flag),
        .rdata      (rdata)
    );

    xparent_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wdata),
        .pop       (pop),
        .adv       (adv),
        .clear     (cmd_xres),
        .head      (fifo_head),
        .count     (fifo_count)
    );

    xparent_engine #(.CW(CW)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .cmd_start  (cmd_start),
        .cmd_rep    (cmd_rep),
        .cmd_mend   (cmd_mend),
        .cmd_xres   (cmd_xres),
        .fifo_count (fifo_count),
        .fifo_head  (fifo_head),
        .pop        (pop),
        .adv        (adv),
        .eot_set    (eot_set),
        .busy       (busy),
        .cyc_active (cyc_active),
        .txd        (txd)
    );
endmodule

// File: rtl/xparent_serial_tx_chk.sv
// Module: assertion checker bound to the transmitter top.
// Watches the line, the FIFO level, the cyclic flag and the status flag.
module xparent_serial_tx_chk
    import xparent_serial_tx_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_en,
    input logic          wr_en,
    input logic          rd_en,
    input logic [1:0]    addr,
    input logic          txd,
    input logic          busy,
    input logic          cyc_active,
    input logic          cmd_xres,
    input logic          eot_set,
    input logic          eot_flag,
    input logic [CW-1:0] fifo_count
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    assert_line_moves_on_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !cmd_xres) |=> $stable(txd));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_STAT && !eot_set) |=> !eot_flag);

    assert_xres_idles_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_xres |=> (txd && fifo_count == '0 && !cyc_active && !busy));

    assert_cyclic_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_active && wr_en && addr == ADDR_DATA && !cmd_xres) |=> $stable(fifo_count));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));
endmodule

bind xparent_serial_tx xparent_serial_tx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .txd        (txd),
    .busy       (busy),
    .cyc_active (cyc_active),
    .cmd_xres   (cmd_xres),
    .eot_set    (eot_set),
    .eot_flag   (eot_flag),
    .fifo_count (fifo_count)
);

// File: tb/tb_xparent_serial_tx.sv
module tb_xparent_serial_tx;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       txd;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xparent_serial_tx #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .txd(txd)
    );

    function automatic logic exp_bit(input logic [7:0] b, input int i);
        return b[i];
    endfunction

    function automatic logic [7:0] exp_status(input logic eot);
        return eot ? 8'h40 : 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
    endtask

    task automatic read_status(input logic eot, input string req);
        rd_en = 1'b1; addr = 2'd2;
        #1;
        check(req, rdata, exp_status(eot));
        @(negedge clk);
        rd_en = 1'b0; addr = 2'd0;
    endtask

    task automatic tick();
        repeat ($urandom % 3) @(negedge clk);
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic expect_byte(input logic [7:0] b, input string req);
        for (int i = 0; i < 8; i++) begin
            tick();
            check(req, {7'b0, txd}, {7'b0, exp_bit(b, i)});
        end
    endtask

    task automatic expect_idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            tick();
            check(req, {7'b0, txd}, 8'h01);
        end
    endtask

    logic [7:0] q[$];
    bit done = 1'b0;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 idle line", {7'b0, txd}, 8'h01);
        read_status(1'b0, "R1 status after reset");

        // R2/R3/R4: one-shot sends with random data, plus directed patterns
        for (int it = 0; it < 6; it++) begin
            q.delete();
            if (it == 0) begin q.push_back(8'h00); q.push_back(8'hFF); q.push_back(8'hA5); end
            else begin
                int n = 1 + ($urandom % 6);
                for (int k = 0; k < n; k++) q.push_back(8'($urandom));
            end
            foreach (q[k]) host_wr(2'd0, q[k]);
            host_wr(2'd1, 8'h08);
            foreach (q[k]) expect_byte(q[k], "R2 one-shot bit");
            tick();
            check("R3 line high after last bit", {7'b0, txd}, 8'h01);
            read_status(1'b1, "R3 end flag set");
            read_status(1'b0, "R4 flag cleared by read");
        end

        // R9: start on empty FIFO does nothing
        host_wr(2'd1, 8'h08);
        expect_idle(10, "R9 empty start idle");
        read_status(1'b0, "R9 no end flag on empty start");

        // R5/R7/R6: cyclic with three bytes
        q.delete();
        for (int k = 0; k < 3; k++) q.push_back(8'($urandom));
        foreach (q[k]) host_wr(2'd0, q[k]);
        host_wr(2'd1, 8'h2A);
        for (int p = 0; p < 3; p++) foreach (q[k]) expect_byte(q[k], "R5 cyclic replay");
        host_wr(2'd0, 8'h3C);
        host_wr(2'd0, 8'hC3);
        for (int p = 0; p < 2; p++) foreach (q[k]) expect_byte(q[k], "R7 write ignored in cyclic");
        expect_byte(q[0], "R5 cyclic replay");
        tick(); tick(); tick();
        host_wr(2'd1, 8'h01);
        check("R6 line high after reset command", {7'b0, txd}, 8'h01);
        expect_idle(12, "R6 idle after reset command");
        read_status(1'b0, "R6 no end flag from reset");
        host_wr(2'd1, 8'h08);
        expect_idle(8, "R6 FIFO emptied");

        // R5: single-byte loop corner
        host_wr(2'd0, 8'h96);
        host_wr(2'd1, 8'h2A);
        for (int p = 0; p < 4; p++) expect_byte(8'h96, "R5 one-byte loop");
        host_wr(2'd1, 8'h09);
        expect_idle(8, "R6 reset wins over start");

        // R8: fill 33 bytes, only 32 sent
        q.delete();
        for (int k = 0; k < DEPTH + 1; k++) begin
            logic [7:0] b = 8'($urandom);
            host_wr(2'd0, b);
            if (k < DEPTH) q.push_back(b);
        end
        host_wr(2'd1, 8'h08);
        foreach (q[k]) expect_byte(q[k], "R8 full FIFO content");
        tick();
        check("R8 no 33rd byte", {7'b0, txd}, 8'h01);
        read_status(1'b1, "R8 end flag after 32 bytes");

        // R10 and R9: 28h is one-shot; start while busy ignored
        q.delete();
        q.push_back(8'h5A); q.push_back(8'h81);
        foreach (q[k]) host_wr(2'd0, q[k]);
        host_wr(2'd1, 8'h28);
        expect_byte(q[0], "R10 no-message-end start");
        host_wr(2'd1, 8'h2A);
        expect_byte(q[1], "R9 start while busy ignored");
        tick();
        check("R10 ends as one-shot", {7'b0, txd}, 8'h01);
        read_status(1'b1, "R10 end flag set");
        expect_idle(4, "R9 no restart");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule